// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between an interrupt source unit and one processor. It keeps a 32-bit pending word that holds the processor's current priority threshold in bits 31:24 and the number of the source now being presented in bits 23:0. A source field of zero means nothing is pending. Alongside the word it keeps the priority of the pending interrupt and an inter-processor-interrupt (IPI) request priority. Lower priority numbers win. The value 0xFF stands for "none" or "least favoured".

The source unit offers requests, each with a source number and a priority. The presenter either takes a request into its pending slot and raises the interrupt line, or bounces it back with a reject strobe. A request that wins the slot also bounces back the request it displaces. The processor works on the presenter through a one-cycle operation port. The operations are accept, poll, set threshold, set IPI priority and end of interrupt. Any of these may sit in the same cycle as an incoming request. Toward the source unit the block drives reject, end-of-interrupt and resend strobes. Every output is registered.

Top module: `irq_presenter`

## Requirements
- R1: After reset, the pending word reads 0, the IPI priority reads 0xFF, the interrupt line is low and no strobe is active.
- R2: A request whose priority is below the threshold, with nothing pending, takes the slot. The line rises, the source field shows its number and the threshold is unchanged.
- R3: A request whose priority is greater than or equal to the threshold is rejected: req_rej pulses with its number and the pending word is unchanged.
- R4: A request is rejected when a pending interrupt exists whose priority is less than or equal to the request's priority.
- R5: A request that beats the pending interrupt takes the slot. The displaced source number pulses on req_rej and the line stays high.
- R6: Accept (op code 0) returns the pending word as it was before the operation and lowers the line. It then sets the threshold to the accepted priority and clears the source field.
- R7: Set-IPI (op code 3) stores bits 7:0 as the IPI priority. If the value is below the threshold and the IPI check is not blocked, the block rejects any pending source, loads source number 2 with the IPI priority and raises the line. A value not below the threshold is only stored.
- R8: The IPI check does nothing when a pending interrupt has a priority less than or equal to the IPI priority.
- R9: Set-threshold (op code 2) with a lower value in bits 7:0 cancels a pending interrupt whose priority is greater than or equal to the new threshold. The cancel pulses op_rej with that source, clears the field and lowers the line. A pending interrupt with a better priority is kept.
- R10: Set-threshold with a value not lower than the current one, while nothing is pending, pulses resend. Before that it loads the IPI (source 2) if the IPI priority is below the new threshold.
- R11: End of interrupt (op code 4) copies bits 31:24 of the written word into the threshold and pulses op_eoi with bits 23:0 on op_num. If nothing is pending it also performs the resend of R10. op_rej and op_eoi never pulse together.
- R12: Poll (op code 1) returns the pending word and the IPI priority and changes no state.
- R13: When an operation and a request arrive in the same cycle, the operation is applied first and the request is judged against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Presentation request from the source unit |
| req_src | input | SRC_W | Source number of the request |
| req_prio | input | PRIO_W | Priority of the request |
| op_valid | input | 1 | Processor operation valid for one cycle |
| op_code | input | 3 | 0 accept, 1 poll, 2 set threshold, 3 set IPI, 4 end of interrupt |
| op_wdata | input | PRIO_W+SRC_W | Operation write word |
| rd_valid | output | 1 | Read result valid (accept or poll) |
| rd_pend | output | PRIO_W+SRC_W | Pending word returned by accept or poll |
| rd_ipi | output | PRIO_W | IPI priority returned by accept or poll |
| irq_out | output | 1 | Interrupt line to the processor |
| op_rej | output | 1 | Reject strobe caused by an operation |
| op_eoi | output | 1 | End-of-interrupt strobe |
| op_num | output | SRC_W | Source number for op_rej or op_eoi |
| resend | output | 1 | Resend request strobe to the source unit |
| req_rej | output | 1 | Reject strobe from request evaluation |
| req_rej_num | output | SRC_W | Source number for req_rej |

## Verification
All state and all outputs are updated at the same clock edge. A stimulus applied before edge k therefore shows its strobes, read data and line level just after edge k, and a later poll issued before edge k+1 reports the new pending word just after edge k+1. The bench drives inputs one time step after an edge and samples one time step after the next edge, so each check lands one edge after its stimulus. Sweeps over threshold against request priority, and pending priority against incoming priority, compare the reject decision and the bounced number with values the bench computes by simple comparison.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;
  typedef enum logic [2:0] {
    OP_ACCEPT  = 3'd0,
    OP_POLL    = 3'd1,
    OP_SET_THR = 3'd2,
    OP_SET_IPI = 3'd3,
    OP_EOI     = 3'd4
  } pres_op_e;
endpackage

// File: rtl/ipr_op_unit.sv
// Applies one processor operation to the presenter state (first stage).
module ipr_op_unit #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic                      op_valid,
  input  irq_presenter_pkg::pres_op_e op_code,
  input  logic [PRIO_W+SRC_W-1:0]   op_wdata,
  input  logic [PRIO_W-1:0]         thr,
  input  logic [SRC_W-1:0]          src,
  input  logic [PRIO_W-1:0]         pprio,
  input  logic [PRIO_W-1:0]         ipi,
  output logic [PRIO_W-1:0]         a_thr,
  output logic [SRC_W-1:0]          a_src,
  output logic [PRIO_W-1:0]         a_pprio,
  output logic [PRIO_W-1:0]         a_ipi,
  output logic                      chk_en,
  output logic                      a_rej,
  output logic                      a_eoi,
  output logic [SRC_W-1:0]          a_num,
  output logic                      a_resend,
  output logic                      rd_en
);
  import irq_presenter_pkg::*;

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  logic [PRIO_W-1:0] w_lo;
  logic [PRIO_W-1:0] w_hi;
  logic [SRC_W-1:0]  w_src;
  logic              busy;

  assign w_lo  = op_wdata[PRIO_W-1:0];
  assign w_hi  = op_wdata[WORD_W-1 -: PRIO_W];
  assign w_src = op_wdata[SRC_W-1:0];
  assign busy  = (src != '0);

  always_comb begin
    a_thr    = thr;
    a_src    = src;
    a_pprio  = pprio;
    a_ipi    = ipi;
    chk_en   = 1'b0;
    a_rej    = 1'b0;
    a_eoi    = 1'b0;
    a_num    = '0;
    a_resend = 1'b0;
    rd_en    = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_ACCEPT: begin
          rd_en   = 1'b1;
          a_thr   = pprio;
          a_src   = '0;
          a_pprio = PRIO_NONE;
        end
        OP_POLL: begin
          rd_en = 1'b1;
        end
        OP_SET_IPI: begin
          a_ipi  = w_lo;
          chk_en = (w_lo < thr);
        end
        OP_SET_THR: begin
          a_thr = w_lo;
          if (w_lo < thr) begin
            if (busy && (w_lo <= pprio)) begin
              a_rej   = 1'b1;
              a_num   = src;
              a_src   = '0;
              a_pprio = PRIO_NONE;
            end
          end else if (!busy) begin
            a_resend = 1'b1;
            chk_en   = (ipi < w_lo);
          end
        end
        OP_EOI: begin
          a_thr = w_hi;
          a_eoi = 1'b1;
          a_num = w_src;
          if (!busy) begin
            a_resend = 1'b1;
            chk_en   = (ipi < w_hi);
          end
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/ipr_ipi_check.sv
// Places the IPI into the pending slot unless a better-or-equal interrupt holds it.
module ipr_ipi_check #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic              en,
  input  logic [SRC_W-1:0]  src_in,
  input  logic [PRIO_W-1:0] pprio_in,
  input  logic [PRIO_W-1:0] ipi,
  output logic [SRC_W-1:0]  src_out,
  output logic [PRIO_W-1:0] pprio_out,
  output logic              rej,
  output logic [SRC_W-1:0]  rej_num
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic held;
  assign held = (src_in != '0) && (pprio_in <= ipi);

  always_comb begin
    src_out   = src_in;
    pprio_out = pprio_in;
    rej       = 1'b0;
    rej_num   = '0;
    if (en && !held) begin
      if (src_in != '0) begin
        rej     = 1'b1;
        rej_num = src_in;
      end
      src_out   = IPI_NUM;
      pprio_out = ipi;
    end
  end
endmodule

// File: rtl/ipr_req_arbiter.sv
// Judges an incoming request against the state left by the operation stage.
module ipr_req_arbiter #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] thr,
  input  logic [SRC_W-1:0]  cur_src,
  input  logic [PRIO_W-1:0] cur_pprio,
  output logic [SRC_W-1:0]  n_src,
  output logic [PRIO_W-1:0] n_pprio,
  output logic              rej,
  output logic [SRC_W-1:0]  rej_num
);
  logic lose;
  assign lose = (req_prio >= thr) || ((cur_src != '0) && (cur_pprio <= req_prio));

  always_comb begin
    n_src   = cur_src;
    n_pprio = cur_pprio;
    rej     = 1'b0;
    rej_num = '0;
    if (req_valid) begin
      if (lose) begin
        rej     = 1'b1;
        rej_num = req_src;
      end else begin
        if (cur_src != '0) begin
          rej     = 1'b1;
          rej_num = cur_src;
        end
        n_src   = req_src;
        n_pprio = req_prio;
      end
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [PRIO_W-1:0]       req_prio,
  input  logic                    op_valid,
  input  logic [2:0]              op_code,
  input  logic [PRIO_W+SRC_W-1:0] op_wdata,
  output logic                    rd_valid,
  output logic [PRIO_W+SRC_W-1:0] rd_pend,
  output logic [PRIO_W-1:0]       rd_ipi,
  output logic                    irq_out,
  output logic                    op_rej,
  output logic                    op_eoi,
  output logic [SRC_W-1:0]        op_num,
  output logic                    resend,
  output logic                    req_rej,
  output logic [SRC_W-1:0]        req_rej_num
);
  import irq_presenter_pkg::*;

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  logic [PRIO_W-1:0] thr_q, pprio_q, ipi_q;
  logic [SRC_W-1:0]  src_q;

  logic [PRIO_W-1:0] a_thr, a_pprio, a_ipi;
  logic [SRC_W-1:0]  a_src, a_num;
  logic              chk_en, a_rej, a_eoi, a_resend, rd_en;

  logic [SRC_W-1:0]  c_src, c_num;
  logic [PRIO_W-1:0] c_pprio;
  logic              c_rej;

  logic [SRC_W-1:0]  r_src, r_num;
  logic [PRIO_W-1:0] r_pprio;
  logic              r_rej;

  pres_op_e op_e;
  assign op_e = pres_op_e'(op_code);

  ipr_op_unit #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_op (
    .op_valid(op_valid), .op_code(op_e), .op_wdata(op_wdata),
    .thr(thr_q), .src(src_q), .pprio(pprio_q), .ipi(ipi_q),
    .a_thr(a_thr), .a_src(a_src), .a_pprio(a_pprio), .a_ipi(a_ipi),
    .chk_en(chk_en), .a_rej(a_rej), .a_eoi(a_eoi), .a_num(a_num),
    .a_resend(a_resend), .rd_en(rd_en)
  );

  ipr_ipi_check #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_ipi (
    .en(chk_en), .src_in(a_src), .pprio_in(a_pprio), .ipi(a_ipi),
    .src_out(c_src), .pprio_out(c_pprio), .rej(c_rej), .rej_num(c_num)
  );

  ipr_req_arbiter #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_arb (
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .thr(a_thr), .cur_src(c_src), .cur_pprio(c_pprio),
    .n_src(r_src), .n_pprio(r_pprio), .rej(r_rej), .rej_num(r_num)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q       <= '0;
      src_q       <= '0;
      pprio_q     <= PRIO_NONE;
      ipi_q       <= PRIO_NONE;
      irq_out     <= 1'b0;
      rd_valid    <= 1'b0;
      rd_pend     <= '0;
      rd_ipi      <= '0;
      op_rej      <= 1'b0;
      op_eoi      <= 1'b0;
      op_num      <= '0;
      resend      <= 1'b0;
      req_rej     <= 1'b0;
      req_rej_num <= '0;
    end else begin
      thr_q       <= a_thr;
      src_q       <= r_src;
      pprio_q     <= r_pprio;
      ipi_q       <= a_ipi;
      irq_out     <= (r_src != '0);
      rd_valid    <= rd_en;
      if (rd_en) begin
        rd_pend <= {thr_q, src_q};
        rd_ipi  <= ipi_q;
      end
      op_rej      <= a_rej | c_rej;
      op_eoi      <= a_eoi;
      op_num      <= c_rej ? c_num : a_num;
      resend      <= a_resend;
      req_rej     <= r_rej;
      req_rej_num <= r_num;
    end
  end

  logic [WORD_W-1:0] unused_width_ref;
  assign unused_width_ref = '0;
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic [SRC_W-1:0]        req_src,
  input logic [PRIO_W-1:0]       req_prio,
  input logic                    op_valid,
  input logic [2:0]              op_code,
  input logic [PRIO_W+SRC_W-1:0] op_wdata,
  input logic                    irq_out,
  input logic                    rd_valid,
  input logic                    op_rej,
  input logic                    op_eoi,
  input logic [SRC_W-1:0]        op_num,
  input logic                    resend,
  input logic                    req_rej,
  input logic [SRC_W-1:0]        req_rej_num,
  input logic [PRIO_W-1:0]       thr_q,
  input logic [SRC_W-1:0]        src_q,
  input logic [PRIO_W-1:0]       pprio_q
);
  import irq_presenter_pkg::*;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && thr_q == '0 && src_q == '0 && !op_rej && !req_rej && !resend));

  assert_reject_above_thr_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !op_valid && req_prio >= thr_q) |=>
      (req_rej && req_rej_num == $past(req_src) && $stable(src_q)));

  assert_accept_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ACCEPT && !req_valid) |=> (!irq_out && rd_valid && src_q == '0));

  assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SET_THR && !req_valid && src_q != '0 &&
     op_wdata[PRIO_W-1:0] < thr_q && op_wdata[PRIO_W-1:0] <= pprio_q) |=>
      (op_rej && op_num == $past(src_q) && !irq_out));

  assert_eoi_forward_R11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_EOI) |=> (op_eoi && op_num == $past(op_wdata[SRC_W-1:0])));

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(op_rej && op_eoi));

  assert_poll_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_POLL && !req_valid) |=>
      ($stable(src_q) && $stable(thr_q) && $stable(pprio_q) && rd_valid));
endmodule

bind irq_presenter irq_presenter_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
  .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata), .irq_out(irq_out),
  .rd_valid(rd_valid), .op_rej(op_rej), .op_eoi(op_eoi), .op_num(op_num),
  .resend(resend), .req_rej(req_rej), .req_rej_num(req_rej_num),
  .thr_q(thr_q), .src_q(src_q), .pprio_q(pprio_q)
);

// File: tb/irq_presenter_test.sv
`timescale 1ns/1ps
module irq_presenter_test;
  localparam int CLK_NS = 10;
  localparam logic [2:0] C_ACC = 3'd0, C_POLL = 3'd1, C_THR = 3'd2, C_IPI = 3'd3, C_EOI = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0] req_prio = '0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [31:0] op_wdata = '0;
  logic rd_valid, irq_out, op_rej, op_eoi, resend, req_rej;
  logic [31:0] rd_pend;
  logic [7:0] rd_ipi;
  logic [23:0] op_num, req_rej_num;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_presenter uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata),
    .rd_valid(rd_valid), .rd_pend(rd_pend), .rd_ipi(rd_ipi), .irq_out(irq_out),
    .op_rej(op_rej), .op_eoi(op_eoi), .op_num(op_num), .resend(resend),
    .req_rej(req_rej), .req_rej_num(req_rej_num)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, sample just after the edge that consumes it
  task automatic cyc(input logic ov, input logic [2:0] oc, input logic [31:0] wd,
                     input logic rv, input logic [23:0] rs, input logic [7:0] rp);
    op_valid = ov; op_code = oc; op_wdata = wd;
    req_valid = rv; req_src = rs; req_prio = rp;
    @(posedge clk);
    #1;
    op_valid = 1'b0; req_valid = 1'b0;
  endtask

  task automatic op(input logic [2:0] oc, input logic [31:0] wd);
    cyc(1'b1, oc, wd, 1'b0, 24'h0, 8'h0);
  endtask

  task automatic rq(input logic [23:0] rs, input logic [7:0] rp);
    cyc(1'b0, 3'd0, 32'h0, 1'b1, rs, rp);
  endtask

  task automatic poll_chk(input string tag, input logic [31:0] pend, input logic [7:0] ipi);
    op(C_POLL, 32'h0);
    check(tag, rd_pend, pend);
    check(tag, {24'h0, rd_ipi}, {24'h0, ipi});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    cyc(1'b0, 3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
    check("R1 irq", {31'h0, irq_out}, 32'h0);
    check("R1 strobes", {28'h0, op_rej, op_eoi, resend, req_rej}, 32'h0);
    poll_chk("R1 poll", 32'h0000_0000, 8'hFF);

    op(C_THR, 32'h80);
    check("R10 resend", {31'h0, resend}, 32'h1);
    check("R10 no ipi", {31'h0, irq_out}, 32'h0);
    poll_chk("R10 poll", 32'h8000_0000, 8'hFF);

    rq(24'h123, 8'h40);
    check("R2 irq", {31'h0, irq_out}, 32'h1);
    check("R2 rej", {31'h0, req_rej}, 32'h0);
    poll_chk("R2 poll", 32'h8000_0123, 8'hFF);

    rq(24'h77, 8'h40);
    check("R4 rej", {31'h0, req_rej}, 32'h1);
    check("R4 num", {8'h0, req_rej_num}, 32'h77);
    poll_chk("R4 poll", 32'h8000_0123, 8'hFF);

    rq(24'h55, 8'h20);
    check("R5 rej", {31'h0, req_rej}, 32'h1);
    check("R5 num", {8'h0, req_rej_num}, 32'h123);
    check("R5 irq", {31'h0, irq_out}, 32'h1);
    poll_chk("R5 poll", 32'h8000_0055, 8'hFF);

    rq(24'h99, 8'h80);
    check("R3 rej", {31'h0, req_rej}, 32'h1);
    check("R3 num", {8'h0, req_rej_num}, 32'h99);
    poll_chk("R3 poll", 32'h8000_0055, 8'hFF);

    op(C_ACC, 32'h0);
    check("R6 rd_valid", {31'h0, rd_valid}, 32'h1);
    check("R6 word", rd_pend, 32'h8000_0055);
    check("R6 irq", {31'h0, irq_out}, 32'h0);
    poll_chk("R6 poll", 32'h2000_0000, 8'hFF);

    op(C_EOI, 32'h8000_0055);
    check("R11 eoi", {31'h0, op_eoi}, 32'h1);
    check("R11 num", {8'h0, op_num}, 32'h55);
    check("R11 resend", {31'h0, resend}, 32'h1);
    poll_chk("R11 poll", 32'h8000_0000, 8'hFF);

    op(C_IPI, 32'h90);
    check("R7 store only", {31'h0, irq_out}, 32'h0);
    poll_chk("R7 poll", 32'h8000_0000, 8'h90);
    op(C_IPI, 32'h30);
    check("R7 irq", {31'h0, irq_out}, 32'h1);
    check("R7 no rej", {31'h0, op_rej}, 32'h0);
    poll_chk("R7 poll ipi", 32'h8000_0002, 8'h30);

    rq(24'h10, 8'h10);
    check("R5 ipi displaced", {8'h0, req_rej_num}, 32'h2);
    op(C_IPI, 32'h20);
    check("R8 no rej", {31'h0, op_rej}, 32'h0);
    poll_chk("R8 poll", 32'h8000_0010, 8'h20);
    op(C_IPI, 32'h05);
    check("R7 rej", {31'h0, op_rej}, 32'h1);
    check("R7 num", {8'h0, op_num}, 32'h10);
    poll_chk("R7 poll2", 32'h8000_0002, 8'h05);

    op(C_THR, 32'h05);
    check("R9 rej", {31'h0, op_rej}, 32'h1);
    check("R9 num", {8'h0, op_num}, 32'h2);
    check("R9 irq", {31'h0, irq_out}, 32'h0);
    poll_chk("R9 poll", 32'h0500_0000, 8'h05);

    op(C_THR, 32'hFF);
    check("R10 resend ipi", {31'h0, resend}, 32'h1);
    check("R10 irq", {31'h0, irq_out}, 32'h1);
    poll_chk("R10 poll ipi", 32'hFF00_0002, 8'h05);
    op(C_THR, 32'h06);
    check("R9 keep", {30'h0, op_rej, irq_out}, 32'h1);
    poll_chk("R9 poll keep", 32'h0600_0002, 8'h05);

    cyc(1'b1, C_ACC, 32'h0, 1'b1, 24'h44, 8'h03);
    check("R13 word", rd_pend, 32'h0600_0002);
    check("R13 irq", {31'h0, irq_out}, 32'h1);
    check("R13 no rej", {31'h0, req_rej}, 32'h0);
    poll_chk("R13 poll", 32'h0500_0044, 8'h05);
    cyc(1'b1, C_THR, 32'h02, 1'b1, 24'h33, 8'h01);
    check("R13 cancel", {31'h0, op_rej}, 32'h1);
    check("R13 cancel num", {8'h0, op_num}, 32'h44);
    check("R13 req kept", {31'h0, req_rej}, 32'h0);
    poll_chk("R13 poll2", 32'h0200_0033, 8'h05);

    do_reset();
    // sweep: threshold against request priority (R2, R3)
    for (int t = 0; t <= 255; t += 15) begin
      for (int p = 0; p <= 255; p += 17) begin
        logic lose;
        lose = (p >= t);
        op(C_EOI, {t[7:0], 24'h0});
        rq(24'h100 + 24'(p), p[7:0]);
        check(lose ? "R3 sweep rej" : "R2 sweep rej", {31'h0, req_rej}, {31'h0, lose});
        check("R2 sweep irq", {31'h0, irq_out}, {31'h0, !lose});
        if (!lose) op(C_ACC, 32'h0);
      end
    end

    // sweep: pending priority against incoming priority (R4, R5)
    op(C_EOI, 32'hFF00_0000);
    for (int a = 0; a <= 253; a += 23) begin
      for (int b = 0; b <= 253; b += 23) begin
        rq(24'h0A, a[7:0]);
        rq(24'h0B, b[7:0]);
        check("R4 sweep rej", {31'h0, req_rej}, 32'h1);
        check((a <= b) ? "R4 sweep num" : "R5 sweep num",
              {8'h0, req_rej_num}, (a <= b) ? 32'h0B : 32'h0A);
        op(C_ACC, 32'h0);
        op(C_EOI, 32'hFF00_0000);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule